// File: doc/BRIEF.md
# Synthesizer Serial Configuration Register

This block takes 24-bit programming words for a frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. Bits enter a shift register most significant bit first, one on each rising edge of the serial clock. When the load strobe rises, the two lowest bits of the word pick which of three holding latches receives the upper 22 bits. The three latches are the reference divider word, the dual-modulus counter word and the function word. The decoded fields leave the block as parallel outputs for the divider and control logic. Analog settings such as charge-pump current are only held as bit fields.

The serial pins are oversampled by the system clock through a configurable synchronizer. A control module detects edges and issues a small set of strobes. A datapath module holds the shift register and the latches. The input side keeps accepting and latching words while the device is powered down, either by the stored power-down bit or by the chip-enable pin. Stored settings survive chip-enable cycling.

Top module: `synthCfgPort`

## Requirements
- R1: On each rising edge of `serClk` the `serData` level enters the bottom of the shift register and the older bits move up one place, so the first bit sent ends at DB23 and the last at DB0.
- R2: A rising edge of `loadEn` with control bits DB1:DB0 = 00 copies DB23:DB2 into the reference latch, shown on `refWord` (bit i = DB(i+2)).
- R3: Control bits 01 load the counter latch: `aCount` = DB7:DB2, `bCount` = DB20:DB8, `ldPrecise` = DB21 (1 selects the narrow lock window).
- R4: Control bits 10 load the function latch: `cntReset` = DB2, `pwrDown` = DB3, `muxSel` = DB6:DB4, `pdPolarity` = DB7, `cpTristate` = DB8, `cpCurrent` = DB17:DB15, `prescSel` = DB23:DB22.
- R5: A word whose control bits are 11 is discarded, and no latch output changes.
- R6: A load changes only the latch its control bits select. The other two keep their contents.
- R7: After reset every latch output is zero.
- R8: Words are accepted and latched while `chipEn` is low or while the stored power-down bit is 1.
- R9: Latched contents are kept unchanged while `chipEn` goes low and comes back high.
- R10: `pwrDownEff` is 1 when `chipEn` is low or the stored power-down bit is 1, and 0 otherwise.
- R11: When more than 24 bits are clocked in before the strobe, the last 24 bits sent form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| chipEn | input | 1 | Chip enable; low forces power-down |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serData | input | 1 | Serial data, MSB first |
| loadEn | input | 1 | Load strobe; transfer happens on its rising edge |
| refWord | output | 22 | Reference latch contents DB23:DB2 |
| aCount | output | 6 | A counter value |
| bCount | output | 13 | B counter value |
| ldPrecise | output | 1 | Lock-detect precision select |
| cntReset | output | 1 | Counter reset bit |
| pwrDown | output | 1 | Stored power-down bit |
| muxSel | output | 3 | Output multiplexer select |
| pdPolarity | output | 1 | Phase detector polarity |
| cpTristate | output | 1 | Charge pump three-state |
| cpCurrent | output | 3 | Charge pump current setting |
| prescSel | output | 2 | Prescaler select |
| pwrDownEff | output | 1 | Effective power-down (pin or bit) |

## Verification
The bench builds the block with its default two-stage synchronizer. That depth keeps the load-to-output delay to a few system clocks, so a long random run of words fits in the cycle budget. Serial bits are held for four system clocks per half period, which is well above the synchronizer delay. This lets the bench cover every control code, over-long words, power-down by bit and by pin, and chip-enable cycling.

// File: rtl/synthCfgPkg.sv
package synthCfgPkg;
  localparam int WORD_W    = 24;
  localparam int CTRL_W    = 2;
  localparam int PAYLOAD_W = WORD_W - CTRL_W;
  localparam int NUM_LATCH = 3;

  // word bit positions (DBn) of the decoded fields
  localparam int A_LO = 2,   A_W = 6;
  localparam int B_LO = 8,   B_W = 13;
  localparam int LDP_BIT = 21;
  localparam int CRST_BIT = 2, PDN_BIT = 3;
  localparam int MUX_LO = 4,  MUX_W = 3;
  localparam int POL_BIT = 7, CPT_BIT = 8;
  localparam int CUR_LO = 15, CUR_W = 3;
  localparam int PRE_LO = 22, PRE_W = 2;

  typedef enum logic [CTRL_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_AB   = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_NONE = 2'b11
  } latchSel_e;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadRef;
    logic loadAb;
    logic loadFunc;
  } cfgStrobe_t;
endpackage

// File: rtl/synthCfgCtrl.sv
module synthCfgCtrl
  import synthCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              serData,
  input  logic              loadEn,
  input  logic [CTRL_W-1:0] ctrlBits,
  output cfgStrobe_t        strb
);
  localparam int NUM_IN = 3;
  localparam int LAST   = SYNC_STAGES - 1;

  logic [NUM_IN-1:0] rawIn;
  logic [SYNC_STAGES-1:0] syncChain [NUM_IN];
  logic sclkPrev, lePrev;
  logic sclkRise, leRise;
  latchSel_e sel;

  assign rawIn = {loadEn, serData, serClk};

  for (genvar i = 0; i < NUM_IN; i++) begin : gSync
    if (SYNC_STAGES == 1) begin : gOne
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) syncChain[i] <= '0;
        else        syncChain[i] <= rawIn[i];
    end else begin : gMany
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) syncChain[i] <= '0;
        else        syncChain[i] <= {syncChain[i][SYNC_STAGES-2:0], rawIn[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev <= 1'b0;
      lePrev   <= 1'b0;
    end else begin
      sclkPrev <= syncChain[0][LAST];
      lePrev   <= syncChain[2][LAST];
    end
  end

  assign sclkRise = syncChain[0][LAST] & ~sclkPrev;
  assign leRise   = syncChain[2][LAST] & ~lePrev;
  assign sel      = latchSel_e'(ctrlBits);

  always_comb begin
    strb          = '0;
    strb.shiftEn  = sclkRise;
    strb.shiftBit = syncChain[1][LAST];
    if (leRise) begin
      unique case (sel)
        SEL_REF:  strb.loadRef  = 1'b1;
        SEL_AB:   strb.loadAb   = 1'b1;
        SEL_FUNC: strb.loadFunc = 1'b1;
        SEL_NONE: ;
      endcase
    end
  end

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.loadRef, strb.loadAb, strb.loadFunc}));

  assert_discard_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlBits == 2'b11) |-> !(strb.loadRef || strb.loadAb || strb.loadFunc));
endmodule

// File: rtl/synthCfgDatapath.sv
module synthCfgDatapath
  import synthCfgPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfgStrobe_t        strb,
  input  logic              chipEn,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic [PAYLOAD_W-1:0] refWord,
  output logic [A_W-1:0]    aCount,
  output logic [B_W-1:0]    bCount,
  output logic              ldPrecise,
  output logic              cntReset,
  output logic              pwrDown,
  output logic [MUX_W-1:0]  muxSel,
  output logic              pdPolarity,
  output logic              cpTristate,
  output logic [CUR_W-1:0]  cpCurrent,
  output logic [PRE_W-1:0]  prescSel,
  output logic              pwrDownEff
);
  logic [WORD_W-1:0]    shiftReg;
  logic [NUM_LATCH-1:0] loadVec;
  logic [PAYLOAD_W-1:0] bank [NUM_LATCH];
  logic [WORD_W-1:0]    abWord, funcWord;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strb.shiftBit};

  assign ctrlBits = shiftReg[CTRL_W-1:0];
  assign loadVec  = {strb.loadFunc, strb.loadAb, strb.loadRef};

  for (genvar i = 0; i < NUM_LATCH; i++) begin : gLatch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          bank[i] <= '0;
      else if (loadVec[i]) bank[i] <= shiftReg[WORD_W-1:CTRL_W];

    assert_hold_unselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !loadVec[i] |=> $stable(bank[i]));
  end

  assign abWord   = {bank[1], {CTRL_W{1'b0}}};
  assign funcWord = {bank[2], {CTRL_W{1'b0}}};

  assign refWord    = bank[0];
  assign aCount     = abWord[A_LO +: A_W];
  assign bCount     = abWord[B_LO +: B_W];
  assign ldPrecise  = abWord[LDP_BIT];
  assign cntReset   = funcWord[CRST_BIT];
  assign pwrDown    = funcWord[PDN_BIT];
  assign muxSel     = funcWord[MUX_LO +: MUX_W];
  assign pdPolarity = funcWord[POL_BIT];
  assign cpTristate = funcWord[CPT_BIT];
  assign cpCurrent  = funcWord[CUR_LO +: CUR_W];
  assign prescSel   = funcWord[PRE_LO +: PRE_W];
  assign pwrDownEff = ~chipEn | pwrDown;

  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shiftEn |=> shiftReg == {$past(shiftReg[WORD_W-2:0]), $past(strb.shiftBit)});

  assert_ab_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadAb |=> (aCount == $past(shiftReg[A_LO +: A_W])) &&
                    (bCount == $past(shiftReg[B_LO +: B_W])));

  assert_load_while_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadFunc && pwrDownEff) |=> funcWord[WORD_W-1:CTRL_W] == $past(shiftReg[WORD_W-1:CTRL_W]));

  assert_no_shift_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.shiftEn |=> $stable(shiftReg));
endmodule

// File: rtl/synthCfgPort.sv
module synthCfgPort
  import synthCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chipEn,
  input  logic        serClk,
  input  logic        serData,
  input  logic        loadEn,
  output logic [21:0] refWord,
  output logic [5:0]  aCount,
  output logic [12:0] bCount,
  output logic        ldPrecise,
  output logic        cntReset,
  output logic        pwrDown,
  output logic [2:0]  muxSel,
  output logic        pdPolarity,
  output logic        cpTristate,
  output logic [2:0]  cpCurrent,
  output logic [1:0]  prescSel,
  output logic        pwrDownEff
);
  cfgStrobe_t        strb;
  logic [CTRL_W-1:0] ctrlBits;

  synthCfgCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .loadEn(loadEn), .ctrlBits(ctrlBits), .strb(strb)
  );

  synthCfgDatapath uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .chipEn(chipEn),
    .ctrlBits(ctrlBits), .refWord(refWord), .aCount(aCount), .bCount(bCount),
    .ldPrecise(ldPrecise), .cntReset(cntReset), .pwrDown(pwrDown),
    .muxSel(muxSel), .pdPolarity(pdPolarity), .cpTristate(cpTristate),
    .cpCurrent(cpCurrent), .prescSel(prescSel), .pwrDownEff(pwrDownEff)
  );
endmodule

// File: tb/synthCfgPort_test.sv
module synthCfgPort_test;
  logic clk = 1'b0, rst_n = 1'b0, chipEn = 1'b1;
  logic serClk = 1'b0, serData = 1'b0, loadEn = 1'b0;
  logic [21:0] refWord; logic [5:0] aCount; logic [12:0] bCount;
  logic ldPrecise, cntReset, pwrDown, pdPolarity, cpTristate, pwrDownEff;
  logic [2:0] muxSel, cpCurrent; logic [1:0] prescSel;

  int testCnt = 0, failCnt = 0;
  logic [21:0] expRef = '0, expAb = '0, expFunc = '0;

  always #5 clk = ~clk;

  synthCfgPort uut (.*);

  function automatic logic [31:0] bits(logic [21:0] pay, int hi, int lo);
    logic [23:0] w = {pay, 2'b00};
    return 32'((w >> lo) & ((24'd1 << (hi - lo + 1)) - 1));
  endfunction

  task automatic check(string req, string name, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, name, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = w[i]; waitClk(4);
      serClk = 1'b1;  waitClk(4);
      serClk = 1'b0;
    end
  endtask

  task automatic strobe();
    loadEn = 1'b1; waitClk(4);
    loadEn = 1'b0; waitClk(8);
  endtask

  task automatic writeWord(logic [23:0] w);
    sendBits({8'h0, w}, 24);
    strobe();
    case (w[1:0])
      2'b00: expRef  = w[23:2];
      2'b01: expAb   = w[23:2];
      2'b10: expFunc = w[23:2];
      default: ;
    endcase
  endtask

  task automatic checkAll(string req);
    check(req, "refWord", 32'(refWord), 32'(expRef));
    check(req, "aCount", 32'(aCount), bits(expAb, 7, 2));
    check(req, "bCount", 32'(bCount), bits(expAb, 20, 8));
    check(req, "ldPrecise", 32'(ldPrecise), bits(expAb, 21, 21));
    check(req, "cntReset", 32'(cntReset), bits(expFunc, 2, 2));
    check(req, "pwrDown", 32'(pwrDown), bits(expFunc, 3, 3));
    check(req, "muxSel", 32'(muxSel), bits(expFunc, 6, 4));
    check(req, "pdPolarity", 32'(pdPolarity), bits(expFunc, 7, 7));
    check(req, "cpTristate", 32'(cpTristate), bits(expFunc, 8, 8));
    check(req, "cpCurrent", 32'(cpCurrent), bits(expFunc, 17, 15));
    check(req, "prescSel", 32'(prescSel), bits(expFunc, 23, 22));
    check("R10", "pwrDownEff", 32'(pwrDownEff), 32'(!chipEn || bits(expFunc, 3, 3) != 0));
  endtask

  initial begin
    #(10 * 200000);
    failCnt++; testCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] seedVal;
    seedVal = $urandom(32'd1234);
    waitClk(3); rst_n = 1'b1; waitClk(2);
    checkAll("R7");

    writeWord({13'h1ABC, 9'h0A5, 2'b00}); checkAll("R2");
    writeWord({2'b01, 13'h1234, 6'h2D, 2'b01}); checkAll("R3");
    writeWord({2'b11, 5'h0, 3'b101, 6'h0, 1'b1, 1'b1, 3'b110, 1'b0, 1'b1, 2'b10}); checkAll("R4");

    // R5: code 11 leaves everything as it was
    writeWord(24'hFFFFFF); checkAll("R5");
    writeWord(24'h5A5A5B); checkAll("R5");

    // R11: extra leading bits are pushed out
    sendBits(32'h3, 2);
    writeWord({2'b00, 1'b1, 13'h0F0F, 6'h11, 2'b01}); checkAll("R11");

    // R8: power-down bit set, further loads still land
    writeWord(24'h000008 | 24'h2); checkAll("R8");
    writeWord({22'h2AAAAA, 2'b00}); checkAll("R8");
    chipEn = 1'b0; waitClk(2); checkAll("R10");
    writeWord({22'h155555, 2'b01}); checkAll("R8");
    writeWord({22'h000100, 2'b10}); checkAll("R8");

    // R9: enable cycling keeps contents
    chipEn = 1'b1; waitClk(4); checkAll("R9");
    chipEn = 1'b0; waitClk(20); chipEn = 1'b1; waitClk(4); checkAll("R9");

    // R6: random words of all codes, each load touches only its latch
    for (int k = 0; k < 60; k++) begin
      logic [23:0] w;
      w = 24'($urandom);
      if (k % 7 == 3) chipEn = ~chipEn;
      writeWord(w);
      checkAll("R6");
    end
    chipEn = 1'b1; waitClk(2); checkAll("R10");

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule